// File: doc/BRIEF.md
# Threshold-Driven DMA Burst Requester

This block raises the DMA request line for a byte-wide FIFO. It compares the FIFO fill count with a programmable byte threshold, and the comparison depends on the transfer direction. In receive, the FIFO is emptied to memory. A burst starts when the fill count is above the threshold. In transmit, the FIFO is filled from memory. A burst starts when the fill count is below the threshold.

Once a burst has started, the request stays high until less than one 16-bit word is left to move. In receive that means fewer than two bytes of data. In transmit it means fewer than two free byte locations. The start point and the end point are different, so the request has hysteresis rather than following a simple level compare.

The request is a registered signal. It is also shown as bit 7 of an 8-bit service status byte. Disabling DMA or changing direction drops the request at the next clock edge. The FIFO storage and the DMA bus cycles are not part of this block.

Top module: `dma_burst_req`

## Requirements
- R1: While rst_n is low, and at the first edge after it, dma_req and svc_status are all zero. The internal direction register resets to receive (dir_tx = 0).
- R2: In receive (dir_tx = 0), with DMA enabled, an idle request goes high at the next clock edge when fill_cnt > thresh and fill_cnt >= 2. Equality with the threshold does not start a burst.
- R3: In receive, an active request stays high while fill_cnt >= 2, even when fill_cnt has dropped to or below thresh.
- R4: In receive, an active request goes low at the next clock edge when fill_cnt < 2.
- R5: In transmit (dir_tx = 1), with DMA enabled, an idle request goes high at the next clock edge when fill_cnt < thresh and DEPTH - fill_cnt >= 2.
- R6: In transmit, an active request stays high while DEPTH - fill_cnt >= 2 and goes low at the next edge once DEPTH - fill_cnt < 2.
- R7: When the start condition and the end condition of the current direction hold in the same cycle, the request is low after that edge.
- R8: When dma_en is low, dma_req is low after the next clock edge, whatever the fill count and threshold are.
- R9: In a cycle where dir_tx differs from the direction registered at the previous edge, dma_req is low after the edge. This holds whether or not a burst was in progress.
- R10: svc_status bit 7 always equals dma_req, and bits 6:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | DMA service enable |
| dir_tx | input | 1 | Direction: 0 receive, 1 transmit |
| thresh | input | CNT_W | Burst start threshold in bytes |
| fill_cnt | input | CNT_W | Current FIFO byte count, 0 to DEPTH |
| dma_req | output | 1 | Registered DMA request |
| svc_status | output | 8 | Service status byte, request in bit 7 |

## Verification
Two cases decide the next request value in the same cycle, so they are provoked on purpose.

The first is a start condition that arrives together with the end condition. One example is a receive threshold of 0 with a fill count of 1. Another is a transmit threshold of DEPTH with a full-minus-one FIFO. The first edge must then leave the request low.

The second is a direction change that arrives in a cycle where the new direction's start condition already holds. The request must stay low for that edge and rise only at the following one.

Both cases are driven as directed steps. They also appear in a long seeded random walk of the fill count, with rare direction flips and enable drops. Every edge is compared with a bench model written from the requirements.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic      req;
        xfer_dir_e dir;
    } burst_state_s;

endpackage

// File: rtl/dmareq_level_eval.sv
module dmareq_level_eval
    import dmareq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int WORD_BYTES = 2,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  xfer_dir_e        dir,
    input  logic [CNT_W-1:0] thresh,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             start_ok,
    output logic             end_hit
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WORD_C  = CNT_W'(WORD_BYTES);

    logic [CNT_W-1:0] free_cnt;
    logic             rx_start, rx_end, tx_start, tx_end;

    always_comb begin
        free_cnt = DEPTH_C - fill_cnt;
        rx_start = fill_cnt > thresh;
        rx_end   = fill_cnt < WORD_C;
        tx_start = fill_cnt < thresh;
        tx_end   = free_cnt < WORD_C;
    end

    always_comb begin
        if (dir == DIR_TX) begin
            start_ok = tx_start;
            end_hit  = tx_end;
        end else begin
            start_ok = rx_start;
            end_hit  = rx_end;
        end
    end

endmodule

// File: rtl/dmareq_burst_ctrl.sv
module dmareq_burst_ctrl
    import dmareq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int WORD_BYTES = 2,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en,
    input  xfer_dir_e        dir,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic             start_ok,
    input  logic             end_hit,
    output logic             req
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WORD_C  = CNT_W'(WORD_BYTES);

    burst_state_s state_d, state_q;
    logic         dir_flip;

    always_comb begin
        state_d     = state_q;
        dir_flip    = (dir != state_q.dir);
        state_d.dir = dir;
        if (!dma_en || dir_flip) begin
            state_d.req = 1'b0;
        end else begin
            state_d.req = (state_q.req | start_ok) & ~end_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{req: 1'b0, dir: DIR_RX};
        end else begin
            state_q <= state_d;
        end
    end

    assign req = state_q.req;

    // R8: disabling DMA drops the request at the next edge
    p_disable_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !req);

    // R9: a direction flip blocks the request at the next edge
    p_dir_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != state_q.dir) |=> !req);

    // R4: receive burst ends below one word of data
    p_rx_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_RX && fill_cnt < WORD_C) |=> !req);

    // R6: transmit burst ends below one word of space
    p_tx_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_TX && (DEPTH_C - fill_cnt) < WORD_C) |=> !req);

    // R3: an active receive burst holds while a word remains
    p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && dma_en && dir == DIR_RX && state_q.dir == DIR_RX
         && fill_cnt >= WORD_C) |=> req);

    // R2, R5: a rise needs DMA enabled in the previous cycle
    p_rise_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(dma_en));

endmodule

// File: rtl/dma_burst_req.sv
module dma_burst_req
    import dmareq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int WORD_BYTES = 2,
    parameter int STAT_W     = 8,
    parameter int STAT_BIT   = 7,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              dir_tx,
    input  logic [CNT_W-1:0]  thresh,
    input  logic [CNT_W-1:0]  fill_cnt,
    output logic              dma_req,
    output logic [STAT_W-1:0] svc_status
);
    xfer_dir_e dir;
    logic      start_ok, end_hit;

    assign dir = dir_tx ? DIR_TX : DIR_RX;

    dmareq_level_eval #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
    ) u_eval (
        .dir(dir), .thresh(thresh), .fill_cnt(fill_cnt),
        .start_ok(start_ok), .end_hit(end_hit)
    );

    dmareq_burst_ctrl #(
        .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir(dir),
        .fill_cnt(fill_cnt), .start_ok(start_ok), .end_hit(end_hit),
        .req(dma_req)
    );

    for (genvar i = 0; i < STAT_W; i++) begin : g_status
        if (i == STAT_BIT) begin : g_req_bit
            assign svc_status[i] = dma_req;
        end else begin : g_zero_bit
            assign svc_status[i] = 1'b0;
        end
    end

    // R10: the status byte never shows a bit other than the request bit
    p_status_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(svc_status) == 32'(dma_req));

endmodule

// File: tb/dma_burst_req_bench.sv
module dma_burst_req_bench;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dma_en = 1'b0;
    logic             dir_tx = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic [CNT_W-1:0] fill_cnt = '0;
    logic             dma_req;
    logic [7:0]       svc_status;

    int checks = 0;
    int errors = 0;
    bit exp_req = 0;
    bit exp_dir = 0;

    always #(CLK_NS / 2) clk = ~clk;

    dma_burst_req #(.DEPTH(DEPTH)) u_dma_burst_req (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_tx(dir_tx),
        .thresh(thresh), .fill_cnt(fill_cnt),
        .dma_req(dma_req), .svc_status(svc_status)
    );

    function automatic bit model_next(bit req, bit dq, bit en, bit dir, int th, int fill);
        bit st, sp;
        if (!en || dir != dq) return 1'b0;
        if (!dir) begin
            st = fill > th;
            sp = fill < 2;
        end else begin
            st = fill < th;
            sp = (DEPTH - fill) < 2;
        end
        return (req | st) & ~sp;
    endfunction

    function automatic string pick_tag(bit prev, bit nxt, bit en, bit dir, bit dq);
        if (!en) return "R8";
        if (dir != dq) return "R9";
        if (!dir) return prev ? (nxt ? "R3" : "R4") : (nxt ? "R2" : "R7");
        return prev ? "R6" : (nxt ? "R5" : "R7");
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit en, bit dir, int th, int fill, string tag = "");
        bit nxt;
        string t;
        @(negedge clk);
        dma_en   = en;
        dir_tx   = dir;
        thresh   = CNT_W'(th);
        fill_cnt = CNT_W'(fill);
        nxt = model_next(exp_req, exp_dir, en, dir, th, fill);
        t = (tag != "") ? tag : pick_tag(exp_req, nxt, en, dir, exp_dir);
        @(posedge clk);
        exp_req = nxt;
        exp_dir = dir;
        #(CLK_NS / 4);
        check(t, {7'd0, dma_req}, {7'd0, exp_req});
        check("R10", svc_status, {exp_req, 7'd0});
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fill;
        bit en, dir;
        int th;
        void'($urandom(32'd1284));
        repeat (3) @(posedge clk);
        #(CLK_NS / 4);
        check("R1", {7'd0, dma_req}, 8'd0);
        check("R1", svc_status, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 5, 5, "R2");    // equal to threshold: no start
        step(1, 0, 5, 6, "R2");    // above: start
        step(1, 0, 5, 3, "R3");    // hold below threshold
        step(1, 0, 5, 2, "R3");
        step(1, 0, 5, 1, "R4");    // below a word: end
        step(1, 0, 0, 1, "R7");    // start and end together
        step(1, 1, 8, 4, "R9");    // direction flip blocks
        step(1, 1, 8, 4, "R5");    // then starts
        step(1, 1, 8, 14, "R6");   // two free bytes: hold
        step(1, 1, 8, 15, "R6");   // one free byte: end
        step(1, 1, 16, 15, "R7");  // start and end together
        step(1, 1, 8, 2, "R5");
        step(0, 1, 8, 2, "R8");    // disable drops
        step(0, 1, 8, 0, "R8");
        step(1, 1, 8, 2, "R5");
        step(1, 0, 0, 8, "R9");    // flip during burst
        step(1, 0, 0, 8, "R2");
        fill = 8;
        en = 1;
        dir = 0;
        th = 6;
        for (int i = 0; i < 4000; i++) begin
            fill += int'($urandom_range(4)) - 2;
            if (fill < 0) fill = 0;
            if (fill > DEPTH) fill = DEPTH;
            if ($urandom_range(99) < 4) dir = ~dir;
            en = ($urandom_range(99) >= 6);
            if ($urandom_range(99) < 3) th = int'($urandom_range(DEPTH));
            step(en, dir, th, fill);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule